// File: doc/BRIEF.md
# PCI Rotating-Priority Bus Arbiter

This block is the central arbiter of a shared PCI-style bus. Several external masters and one host CPU requester each drive an active-low request line. The arbiter answers on active-low grant lines, with at most one grant asserted at a time. The request and grant line with the highest index belongs to the CPU. The arbiter watches the bus FRAME and IRDY signals. From them it learns when the holder of the grant has actually begun a transaction.

Priority is kept as a queue, not as a round-robin pointer. A master goes to the tail of the queue only when it starts a transaction. Being granted is not enough. A master that is granted but never drives FRAME keeps its place. When the grant has to move, the old grant is dropped one clock before the new one is raised. This leaves one turnaround cycle with no grant. When nobody requests, the grant parks on the CPU or on the last master that started a transaction, chosen by a configuration input that is sampled on every clock.

Top module: `pcirr_arb`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle.
- R2: While `rst_n` is low, every grant is high. After reset the queue order is index 0 at the head (highest) through the CPU index N-1 at the tail (lowest).
- R3: When no grant is asserted, the next clock grants the requester nearest the head of the queue. With no requester, that clock grants the park target instead.
- R4: When the grant must change owner, it first goes high for exactly one cycle. Only after that cycle is the new grant driven low.
- R5: A transaction start is a clock where `frame_n` is sampled low, the clock before had `frame_n` and `irdy_n` both high, and a grant is held. The grant holder then moves to the tail of the queue, and this takes effect for the arbitration on the following clock. A FRAME assertion that follows a non-idle cycle does not rotate the queue.
- R6: The holder keeps its grant for as long as it is still the chosen owner. This holds during and after its transaction.
- R7: With `park_last`=0 and no request, the grant parks on the CPU index N-1.
- R8: With `park_last`=1 and no request, the grant parks on the master that most recently started a transaction. After reset this is the CPU.
- R9: A granted master that releases its request without starting a transaction loses the grant at the next arbitration unless it is the park target. The queue order does not change.
- R10: `park_last` is sampled on every clock. Changing it while parked moves the grant, with the turnaround cycle of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | NUM_EXT+1 | Active-low requests; bit NUM_EXT is the CPU |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus IRDY, active low |
| park_last | input | 1 | 0: park on the CPU, 1: park on the last transaction starter |
| gnt_n | output | NUM_EXT+1 | Active-low grants, at most one low |

## Verification
The bench checks that a FRAME assertion following a non-idle cycle leaves the queue alone. A design that rotated on it would hand the bus to the next requester too early. It checks that a grant dropped without a transaction does not rotate. A design that rotated on every grant would starve the master that never started. It checks that every owner change passes through a cycle with no grant. Missing that cycle would show two back-to-back grants to different owners. Switching park mode while idle and parking on the last starter are both exercised, because a wrong park target only shows when no one requests.

// File: rtl/pcirr_pkg.sv
package pcirr_pkg;

  typedef enum logic {
    PARK_CPU  = 1'b0,
    PARK_LAST = 1'b1
  } park_mode_e;

endpackage

// File: rtl/pcirr_start_det.sv
module pcirr_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic gnt_held,
  output logic start_evt
);

  logic idle_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) idle_prev_q <= 1'b1;
    else        idle_prev_q <= frame_n & irdy_n;
  end

  assign start_evt = gnt_held & ~frame_n & idle_prev_q;

endmodule

// File: rtl/pcirr_prio_queue.sv
module pcirr_prio_queue #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_act,
  input  logic          rotate,
  input  logic [IW-1:0] rot_idx,
  output logic          win_valid,
  output logic [IW-1:0] winner
);

  logic [N-1:0][IW-1:0] order_q;
  logic [N-1:0][IW-1:0] order_d;
  logic [IW-1:0]        pos;

  function automatic logic [IW:0] pick_head(input logic [N-1:0] act,
                                            input logic [N-1:0][IW-1:0] ord);
    logic [IW:0] res;
    res = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[ord[i]]) res = {1'b1, ord[i]};
    end
    return res;
  endfunction

  function automatic logic [IW-1:0] find_pos(input logic [IW-1:0] idx,
                                             input logic [N-1:0][IW-1:0] ord);
    logic [IW-1:0] p;
    p = '0;
    for (int i = 0; i < N; i++) begin
      if (ord[i] == idx) p = IW'(i);
    end
    return p;
  endfunction

  assign {win_valid, winner} = pick_head(req_act, order_q);
  assign pos = find_pos(rot_idx, order_q);

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == N - 1) begin : g_tail
      assign order_d[i] = rotate ? rot_idx : order_q[i];
    end else begin : g_body
      assign order_d[i] = (rotate && (IW'(i) >= pos)) ? order_q[i+1] : order_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) order_q[i] <= IW'(i);
    end else begin
      order_q <= order_d;
    end
  end

  // R5
  tail_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> order_q[N-1] == $past(rot_idx));

  // R9
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rotate |=> $stable(order_q));

endmodule

// File: rtl/pcirr_grant_ctl.sv
module pcirr_grant_ctl
  import pcirr_pkg::*;
#(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [IW-1:0] winner,
  input  park_mode_e    park_mode,
  input  logic          start_evt,
  output logic          valid_q,
  output logic [IW-1:0] cur_q,
  output logic [N-1:0]  gnt_n
);

  localparam logic [IW-1:0] CPU_IDX = IW'(N - 1);

  logic [IW-1:0] last_q;
  logic [IW-1:0] desired;

  always_comb begin
    if (win_valid)                  desired = winner;
    else if (park_mode == PARK_LAST) desired = last_q;
    else                            desired = CPU_IDX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cur_q   <= CPU_IDX;
      last_q  <= CPU_IDX;
    end else begin
      if (!valid_q) begin
        valid_q <= 1'b1;
        cur_q   <= desired;
      end else if (desired != cur_q) begin
        valid_q <= 1'b0;
      end
      if (start_evt) last_q <= cur_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign gnt_n[i] = ~(valid_q && (cur_q == IW'(i)));
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) <= 1);

  // R4
  owner_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && $past(valid_q) |-> cur_q == $past(cur_q));

  // R3
  head_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !$past(valid_q) && $past(win_valid) |-> cur_q == $past(winner));

  // R6
  owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && win_valid && (winner == cur_q) |=> valid_q && (cur_q == $past(cur_q)));

  // R7
  park_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !$past(valid_q) && !$past(win_valid) && ($past(park_mode) == PARK_CPU)
      |-> cur_q == CPU_IDX);

endmodule

// File: rtl/pcirr_arb.sv
module pcirr_arb
  import pcirr_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_EXT:0] req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             park_last,
  output logic [NUM_EXT:0] gnt_n
);

  localparam int N  = NUM_EXT + 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          start_evt;
  logic          win_valid;
  logic [IW-1:0] winner;
  logic          valid_q;
  logic [IW-1:0] cur_q;
  park_mode_e    park_mode;

  assign park_mode = park_last ? PARK_LAST : PARK_CPU;

  pcirr_start_det u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .gnt_held  (valid_q),
    .start_evt (start_evt)
  );

  pcirr_prio_queue #(.N(N)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_act   (~req_n),
    .rotate    (start_evt),
    .rot_idx   (cur_q),
    .win_valid (win_valid),
    .winner    (winner)
  );

  pcirr_grant_ctl #(.N(N)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .winner    (winner),
    .park_mode (park_mode),
    .start_evt (start_evt),
    .valid_q   (valid_q),
    .cur_q     (cur_q),
    .gnt_n     (gnt_n)
  );

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> &gnt_n);

endmodule

// File: tb/pcirr_arb_test.sv
module pcirr_arb_test;

  localparam int NUM_EXT = 4;
  localparam int N       = NUM_EXT + 1;
  localparam int CPU     = N - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic         park_last = 1'b0;
  logic [N-1:0] gnt_n;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  pcirr_arb #(.NUM_EXT(NUM_EXT)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .park_last (park_last),
    .gnt_n     (gnt_n)
  );

  always #5 clk = ~clk;

  // reference model: priority list as a queue, owner as integers
  int q[$];
  bit m_valid;
  int m_cur;
  int m_last;
  bit m_idle;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {};
      for (int i = 0; i < N; i++) q.push_back(i);
      m_valid = 0;
      m_cur   = CPU;
      m_last  = CPU;
      m_idle  = 1;
    end else begin
      bit st;
      bit found;
      int own;
      int want;
      st    = m_valid && !frame_n && m_idle;
      own   = m_cur;
      found = 0;
      want  = park_last ? m_last : CPU;
      foreach (q[k]) begin
        if (!found && !req_n[q[k]]) begin
          found = 1;
          want  = q[k];
        end
      end
      if (!m_valid) begin
        m_valid = 1;
        m_cur   = want;
      end else if (want != m_cur) begin
        m_valid = 0;
      end
      if (st) begin
        int at;
        at = 0;
        foreach (q[k]) if (q[k] == own) at = k;
        q.delete(at);
        q.push_back(own);
        m_last = own;
      end
      m_idle = frame_n && irdy_n;
    end
  end

  function automatic logic [N-1:0] model_gnt();
    logic [N-1:0] g;
    g = '1;
    if (m_valid) g[m_cur] = 1'b0;
    return g;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (gnt_n !== model_gnt()) begin
        errors++;
        $display("FAIL R3/R4/R6 model: gnt_n=%b expected %b", gnt_n, model_gnt());
      end
      checks++;
      if ($countones(~gnt_n) > 1) begin
        errors++;
        $display("FAIL R1 grants low: gnt_n=%b expected at most one low bit", gnt_n);
      end
    end
  end

  task automatic cyc(input logic [N-1:0] rq, input logic fr, input logic ir,
                     input logic pk, input logic [N-1:0] exp, input string tag);
    req_n = rq; frame_n = fr; irdy_n = ir; park_last = pk;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (gnt_n !== exp) begin
      errors++;
      $display("FAIL %s: gnt_n=%b expected %b", tag, gnt_n, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gnt_n !== '1) begin
      errors++;
      $display("FAIL R2 reset: gnt_n=%b expected %b", gnt_n, 5'b11111);
    end
    rst_n = 1'b1;
    cyc(5'b11111, 1, 1, 0, 5'b01111, "R7 park cpu");
    cyc(5'b11100, 1, 1, 0, 5'b11111, "R4 gap");
    cyc(5'b11100, 1, 1, 0, 5'b11110, "R2 R3 head wins");
    cyc(5'b11100, 0, 1, 0, 5'b11110, "R6 keep at start");
    cyc(5'b11100, 0, 1, 0, 5'b11111, "R5 rotate drop");
    cyc(5'b11100, 0, 1, 0, 5'b11101, "R5 next owner");
    cyc(5'b11100, 1, 1, 0, 5'b11101, "R6 keep");
    cyc(5'b11100, 0, 1, 0, 5'b11101, "R5 start 1");
    cyc(5'b11111, 1, 1, 1, 5'b11101, "R8 park last");
    cyc(5'b11111, 1, 1, 0, 5'b11111, "R10 mode switch gap");
    cyc(5'b11111, 1, 1, 0, 5'b01111, "R7 park cpu again");
    cyc(5'b11011, 1, 1, 1, 5'b11111, "R4 gap to 2");
    cyc(5'b11011, 1, 1, 1, 5'b11011, "R3 grant 2");
    cyc(5'b11111, 1, 1, 1, 5'b11111, "R9 withdraw");
    cyc(5'b11111, 1, 1, 1, 5'b11101, "R8 back to last");
    cyc(5'b10011, 1, 1, 1, 5'b11111, "R9 gap");
    cyc(5'b10011, 1, 1, 1, 5'b11011, "R9 no rotation");
    cyc(5'b10011, 1, 0, 1, 5'b11011, "R6 irdy busy");
    cyc(5'b10011, 0, 0, 1, 5'b11011, "R5 not idle");
    cyc(5'b10011, 0, 0, 1, 5'b11011, "R5 no rotation");
    cyc(5'b10011, 1, 1, 1, 5'b11011, "R6 idle");
    cyc(5'b10011, 0, 1, 1, 5'b11011, "R5 start 2");
    cyc(5'b10011, 0, 1, 1, 5'b11111, "R5 rotated drop");
    cyc(5'b10011, 0, 1, 1, 5'b10111, "R5 grant 3");
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      req_n   = N'($urandom);
      frame_n = ($urandom % 4) != 0;
      irdy_n  = ($urandom % 3) != 0;
      if (($urandom % 32) == 0) park_last = ~park_last;
      if (($urandom % 8) == 0) req_n = '1;
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule